// File: doc/BRIEF.md
# Descriptor Command List Sequencer

This block walks a chain of 16-byte command descriptors held in memory. It reads the first three words of the descriptor at the command pointer and decodes the command half-word. For a data, register-store or register-load command it starts an external transfer engine and waits for it to finish. A no-op needs no engine. A stop command parks the channel on the descriptor that holds it. After a command completes, the sequencer writes the residual byte count and a channel status copy into the fourth word of the descriptor. It then decides, from three independent 2-bit controls, whether to raise an interrupt, whether to branch and whether to stall.

Each control has four settings. 0 means never and 3 means always. 1 acts when a chosen bit of the device status input is 1, and 2 acts when that bit is 0. The bit is picked by a select input: one select for interrupt, one for branch and one for wait. On a taken branch the next pointer is the command-dependent word with its low four bits cleared. Otherwise the pointer moves on by 16.

The FSM has these states. S_IDLE goes to S_FETCH on run. S_FETCH reads three words and then goes to S_DECODE, or to S_DEAD on a memory error. S_DECODE goes to S_XFER for opcodes 0 to 5, to S_WRBACK for a no-op, to S_STOPPED for a stop, and to S_DEAD for opcodes 8 to 15. S_XFER goes to S_WRBACK when the engine reports done, or to S_DEAD on an engine error. S_WRBACK goes to S_EVAL, or to S_DEAD on an error. S_EVAL goes to S_WAIT if the wait condition holds. Otherwise it goes to S_FETCH, or to S_IDLE when run is low. S_WAIT goes to S_FETCH once the wait condition clears, or to S_IDLE when run drops. S_STOPPED goes to S_FETCH on wake, or to S_IDLE when run drops. S_DEAD goes to S_IDLE when run drops.

Top module: `desc_seq`

## Requirements
- R1: After reset the block issues no memory request and no transfer start. It drives cmd_ptr = 0, chan_active = 0, chan_dead = 0 and irq = 0.
- R2: Fetch order. When run is high in idle, the pointer loads start_addr with bits 3:0 cleared. The block then reads ptr, ptr+4 and ptr+8 in that order. Word 0 holds the requested count in bits 15:0 and the command half-word in bits 31:16. Word 1 is the data address and word 2 is the command-dependent word. A request stays up with a stable address until mem_ack.
- R3: Opcodes 0 to 3 give a one-cycle xfer_start. It carries the opcode, the key from command bits 10:8, the data address, and xfer_count equal to the requested count.
- R4: For opcodes 4 (store word) and 5 (load word), xfer_count is 4 whatever the requested count is.
- R5: Write-back goes to address ptr+12. Bits 15:0 carry the residual and bits 31:16 carry the status 0x8400 OR dev_status. The residual is xfer_residual for engine commands and 0 for opcode 6 (no-op).
- R6: Interrupt. Command bits 5:4 are tested against dev_status[irq_sel], with 0 never, 1 if set, 2 if clear and 3 always. When the control is met, irq pulses for exactly one cycle after the write-back.
- R7: Branch. Command bits 3:2 use the same encoding against dev_status[br_sel]. When the branch is taken, the next pointer is the dependent word with bits 3:0 cleared. Otherwise it is ptr+16. cmd_ptr bits 3:0 are always 0.
- R8: Wait. Command bits 1:0 use the same encoding against dev_status[wait_sel]. While the control is met after write-back, the block stays on the descriptor with chan_active = 1 and re-tests the condition every cycle. It advances once the condition clears.
- R9: Opcode 7 (stop) parks the block with chan_active = 0. There is no write-back and cmd_ptr stays unchanged. A wake pulse refetches the same descriptor.
- R10: A memory error on fetch or write-back, an engine error, or an opcode of 8 or above sets chan_dead = 1 with chan_active = 0. After that the block issues no further requests.
- R11: run low while stopped, waiting or dead returns the block to idle. In idle chan_dead = 0 and no fetch is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channel enable level |
| wake | input | 1 | Restart pulse for a stopped channel |
| start_addr | input | ADDR_W | First descriptor address |
| dev_status | input | STAT_W | Device condition bits |
| irq_sel | input | SEL_W | Condition bit index for the interrupt |
| br_sel | input | SEL_W | Condition bit index for the branch |
| wait_sel | input | SEL_W | Condition bit index for the wait |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write-back word |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| mem_err | input | 1 | Request failed, valid with mem_ack |
| xfer_start | output | 1 | One-cycle engine start |
| xfer_opcode | output | 3 | Command code for the engine |
| xfer_key | output | 3 | Stream or space key |
| xfer_addr | output | ADDR_W | Data address |
| xfer_count | output | 16 | Byte count |
| xfer_done | input | 1 | Engine finished |
| xfer_residual | input | 16 | Bytes left untransferred |
| xfer_err | input | 1 | Engine failed, valid with xfer_done |
| cmd_ptr | output | ADDR_W | Current descriptor address |
| chan_active | output | 1 | Sequencer working on a descriptor |
| chan_dead | output | 1 | Channel halted by an error |
| irq | output | 1 | Interrupt pulse |

## Verification
The interrupt and the branch are decided in the same evaluation cycle of one descriptor, and the wait test can join them. Vectors set both controls together, for example a no-op with interrupt always and branch always. For these, the bench counts irq pulses and checks that the channel ends on the stop descriptor at the branch target rather than at ptr+16. Other vectors set only one of the two controls, so the bench also confirms that one decision never carries over into the other.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_XFER,
        S_WRBACK,
        S_EVAL,
        S_WAIT,
        S_STOPPED,
        S_DEAD
    } seq_state_t;

    localparam logic [3:0] OP_STORE = 4'd4;
    localparam logic [3:0] OP_LOAD  = 4'd5;
    localparam logic [3:0] OP_NOP   = 4'd6;
    localparam logic [3:0] OP_STOP  = 4'd7;

    typedef struct packed {
        logic [3:0]  opcode;
        logic [2:0]  key;
        logic [1:0]  irq_ctl;
        logic [1:0]  br_ctl;
        logic [1:0]  wait_ctl;
        logic [15:0] req_count;
        logic [31:0] data_addr;
        logic [27:0] dep_hi;
    } desc_t;

    function automatic logic ctl_met(input logic [1:0] ctl, input logic cbit);
        unique case (ctl)
            2'd0: ctl_met = 1'b0;
            2'd1: ctl_met = cbit;
            2'd2: ctl_met = ~cbit;
            default: ctl_met = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dseq_cond.sv
module dseq_cond #(
    parameter int STAT_W = 8,
    localparam int SEL_W = $clog2(STAT_W)
) (
    input  logic [STAT_W-1:0] status,
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        ctl,
    output logic              met
);
    import dseq_pkg::*;

    always_comb met = ctl_met(ctl, status[sel]);

endmodule

// File: rtl/dseq_desc_store.sv
module dseq_desc_store (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [1:0]       widx,
    input  logic [31:0]      wdata,
    output dseq_pkg::desc_t  desc
);
    import dseq_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc <= '0;
        end else if (capture) begin
            unique case (widx)
                2'd0: begin
                    desc.req_count <= wdata[15:0];
                    desc.opcode    <= wdata[31:28];
                    desc.key       <= wdata[26:24];
                    desc.irq_ctl   <= wdata[21:20];
                    desc.br_ctl    <= wdata[19:18];
                    desc.wait_ctl  <= wdata[17:16];
                end
                2'd1: desc.data_addr <= wdata;
                default: desc.dep_hi <= wdata[31:4];
            endcase
        end
    end

endmodule

// File: rtl/desc_seq.sv
module desc_seq #(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 8,
    localparam int SEL_W = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wake,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [STAT_W-1:0] dev_status,
    input  logic [SEL_W-1:0]  irq_sel,
    input  logic [SEL_W-1:0]  br_sel,
    input  logic [SEL_W-1:0]  wait_sel,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              xfer_start,
    output logic [2:0]        xfer_opcode,
    output logic [2:0]        xfer_key,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [15:0]       xfer_count,
    input  logic              xfer_done,
    input  logic [15:0]       xfer_residual,
    input  logic              xfer_err,
    output logic [ADDR_W-1:0] cmd_ptr,
    output logic              chan_active,
    output logic              chan_dead,
    output logic              irq
);
    import dseq_pkg::*;

    localparam int          DESC_BYTES  = 16;
    localparam int          WORD_BYTES  = 4;
    localparam int          FETCH_WORDS = 3;
    localparam int          NUM_COND    = 3;
    localparam logic [1:0]  LAST_WORD   = 2'(FETCH_WORDS - 1);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] WB_OFFS = ADDR_W'(DESC_BYTES - WORD_BYTES);
    localparam logic [15:0] STAT_BASE   = 16'h8400;

    seq_state_t       state, state_nx;
    logic [1:0]       widx;
    logic [ADDR_W-1:0] ptr;
    logic [15:0]      residual;
    logic             br_take;
    desc_t            desc;
    logic             capture;
    logic [NUM_COND-1:0] cond_met;
    logic [SEL_W-1:0] sel_arr [NUM_COND];
    logic [1:0]       ctl_arr [NUM_COND];
    logic [ADDR_W-1:0] br_target;
    logic             is_engine_op;

    always_comb begin
        sel_arr[0] = irq_sel;   ctl_arr[0] = desc.irq_ctl;
        sel_arr[1] = br_sel;    ctl_arr[1] = desc.br_ctl;
        sel_arr[2] = wait_sel;  ctl_arr[2] = desc.wait_ctl;
    end

    for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
        dseq_cond #(.STAT_W(STAT_W)) u_cond (
            .status (dev_status),
            .sel    (sel_arr[g]),
            .ctl    (ctl_arr[g]),
            .met    (cond_met[g])
        );
    end

    assign capture      = (state == S_FETCH) && mem_ack && !mem_err;
    assign br_target    = ADDR_W'({desc.dep_hi, 4'b0000});
    assign is_engine_op = (desc.opcode <= OP_LOAD);

    dseq_desc_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .widx    (widx),
        .wdata   (mem_rdata),
        .desc    (desc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (run) state_nx = S_FETCH;
            S_FETCH:   if (mem_ack) begin
                           if (mem_err)               state_nx = S_DEAD;
                           else if (widx == LAST_WORD) state_nx = S_DECODE;
                       end
            S_DECODE:  begin
                           if (is_engine_op)               state_nx = S_XFER;
                           else if (desc.opcode == OP_NOP)  state_nx = S_WRBACK;
                           else if (desc.opcode == OP_STOP) state_nx = S_STOPPED;
                           else                            state_nx = S_DEAD;
                       end
            S_XFER:    if (xfer_done) state_nx = xfer_err ? S_DEAD : S_WRBACK;
            S_WRBACK:  if (mem_ack)   state_nx = mem_err ? S_DEAD : S_EVAL;
            S_EVAL:    begin
                           if (cond_met[2]) state_nx = S_WAIT;
                           else             state_nx = run ? S_FETCH : S_IDLE;
                       end
            S_WAIT:    begin
                           if (!run)             state_nx = S_IDLE;
                           else if (!cond_met[2]) state_nx = S_FETCH;
                       end
            S_STOPPED: begin
                           if (!run)      state_nx = S_IDLE;
                           else if (wake) state_nx = S_FETCH;
                       end
            S_DEAD:    if (!run) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx     <= '0;
            ptr      <= '0;
            residual <= '0;
            br_take  <= 1'b0;
        end else begin
            if (state == S_FETCH && mem_ack) begin
                if (mem_err || widx == LAST_WORD) widx <= '0;
                else                               widx <= widx + 2'd1;
            end
            if (state == S_DECODE && desc.opcode == OP_NOP) residual <= '0;
            if (state == S_XFER && xfer_done)                residual <= xfer_residual;
            if (state == S_EVAL) br_take <= cond_met[1];

            if (state == S_IDLE && run)
                ptr <= {start_addr[ADDR_W-1:4], 4'b0000};
            else if (state == S_EVAL && !cond_met[2])
                ptr <= cond_met[1] ? br_target : ptr + STEP;
            else if (state == S_WAIT && run && !cond_met[2])
                ptr <= br_take ? br_target : ptr + STEP;
        end
    end

    // outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = ptr + ADDR_W'({widx, 2'b00});
        mem_wdata   = {STAT_BASE | 16'(dev_status), residual};
        xfer_start  = 1'b0;
        xfer_opcode = desc.opcode[2:0];
        xfer_key    = desc.key;
        xfer_addr   = ADDR_W'(desc.data_addr);
        xfer_count  = (desc.opcode == OP_STORE || desc.opcode == OP_LOAD) ?
                      16'd4 : desc.req_count;
        irq         = 1'b0;
        chan_active = 1'b1;
        chan_dead   = 1'b0;
        unique case (state)
            S_IDLE, S_STOPPED: chan_active = 1'b0;
            S_DEAD: begin
                chan_active = 1'b0;
                chan_dead   = 1'b1;
            end
            S_FETCH:  mem_req = 1'b1;
            S_DECODE: xfer_start = is_engine_op;
            S_WRBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ptr + WB_OFFS;
            end
            S_EVAL:   irq = cond_met[0];
            default:  ;
        endcase
    end

    assign cmd_ptr = ptr;

endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              xfer_start,
    input logic [2:0]        xfer_opcode,
    input logic [15:0]       xfer_count,
    input logic              irq,
    input logic [ADDR_W-1:0] cmd_ptr,
    input logic              chan_active,
    input logic              chan_dead
);

    a_r10_dead_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        chan_dead |-> !chan_active);

    a_r10_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        chan_dead |-> (!mem_req && !xfer_start));

    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    a_r4_word_count: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && (xfer_opcode == 3'd4 || xfer_opcode == 3'd5)) |-> (xfer_count == 16'd4));

    a_r5_wb_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[3:0] == 4'hC));

    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r7_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ptr[3:0] == 4'h0);

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

bind desc_seq dseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .xfer_start  (xfer_start),
    .xfer_opcode (xfer_opcode),
    .xfer_count  (xfer_count),
    .irq         (irq),
    .cmd_ptr     (cmd_ptr),
    .chan_active (chan_active),
    .chan_dead   (chan_dead)
);

// File: tb/desc_seq_bench.sv
module desc_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wake = 1'b0;
    logic [31:0] start_addr = 32'h40;
    logic [7:0]  dev_status = 8'h00;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        xfer_start;
    logic [2:0]  xfer_opcode, xfer_key;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_count;
    logic        xfer_done = 1'b0;
    logic [15:0] xfer_residual = '0;
    logic        xfer_err = 1'b0;
    logic [31:0] cmd_ptr;
    logic        chan_active, chan_dead, irq;

    always #5 clk = ~clk;

    desc_seq u_desc_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .wake(wake), .start_addr(start_addr),
        .dev_status(dev_status), .irq_sel(3'd0), .br_sel(3'd1), .wait_sel(3'd2),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .xfer_start(xfer_start), .xfer_opcode(xfer_opcode), .xfer_key(xfer_key),
        .xfer_addr(xfer_addr), .xfer_count(xfer_count), .xfer_done(xfer_done),
        .xfer_residual(xfer_residual), .xfer_err(xfer_err),
        .cmd_ptr(cmd_ptr), .chan_active(chan_active), .chan_dead(chan_dead), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] mem [0:63];
    logic [31:0] read_log [0:15];
    int  read_n = 0;
    int  n_irq = 0;
    int  n_starts = 0;
    bit  err_on = 1'b0;
    logic [7:0] err_addr = '0;
    bit  inj_xerr = 1'b0;
    logic [15:0] last_count = '0;
    logic [2:0]  last_key = '0;
    logic [31:0] last_addr = '0;

    localparam logic [31:0] SENT = 32'h5A5A5A5A;

    // {command, dev_status, irq expected, final ptr, residual}
    localparam int NV = 13;
    localparam logic [48:0] VECS [0:NV-1] = '{
        {16'h1030, 8'h00, 1'b1, 8'h50, 16'h000F},
        {16'h2110, 8'h01, 1'b1, 8'h50, 16'h000F},
        {16'h3210, 8'h00, 1'b0, 8'h50, 16'h000F},
        {16'h0020, 8'h00, 1'b1, 8'h50, 16'h000F},
        {16'h0004, 8'h02, 1'b0, 8'h80, 16'h000F},
        {16'h0004, 8'h00, 1'b0, 8'h50, 16'h000F},
        {16'h0008, 8'h00, 1'b0, 8'h80, 16'h000F},
        {16'h000C, 8'h00, 1'b0, 8'h80, 16'h000F},
        {16'h4500, 8'h00, 1'b0, 8'h50, 16'h0003},
        {16'h5500, 8'h00, 1'b0, 8'h50, 16'h0003},
        {16'h6000, 8'h00, 1'b0, 8'h50, 16'h0000},
        {16'h603C, 8'h00, 1'b1, 8'h80, 16'h0000},
        {16'h0001, 8'h00, 1'b0, 8'h50, 16'h000F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (mem_req) begin
                mem_ack = 1'b1;
                mem_err = err_on && (mem_addr[7:0] == err_addr);
                if (!mem_err) begin
                    if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
                    else begin
                        mem_rdata = mem[mem_addr[7:2]];
                        read_log[read_n[3:0]] = mem_addr;
                        read_n++;
                    end
                end
            end
        end
    end

    // transfer engine model: residual is count minus one
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_start) begin
                n_starts++;
                last_count = xfer_count;
                last_key   = xfer_key;
                last_addr  = xfer_addr;
                @(negedge clk);
                @(negedge clk);
                xfer_done     = 1'b1;
                xfer_residual = last_count - 16'd1;
                xfer_err      = inj_xerr;
                @(negedge clk);
                xfer_done = 1'b0;
                xfer_err  = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq) n_irq++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic load_desc(input logic [15:0] cmd);
        for (int k = 0; k < 64; k++) mem[k] = 32'h0;
        mem[16] = {cmd, 16'h0010};
        mem[17] = 32'h0000_1000;
        mem[18] = 32'h0000_0087;
        mem[19] = SENT;
        mem[20] = {16'h7000, 16'h0000};
        mem[23] = SENT;
        mem[32] = {16'h7000, 16'h0000};
    endtask

    task automatic go_and_settle();
        n_irq = 0;
        n_starts = 0;
        read_n = 0;
        run = 1'b1;
        repeat (2) @(negedge clk);
        while (chan_active) @(negedge clk);
    endtask

    task automatic stop_run();
        run = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [15:0] cmd;
        logic [7:0]  dv;
        int          saved;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 active", {31'b0, chan_active}, 32'd0);
        chk("R1 dead", {31'b0, chan_dead}, 32'd0);
        chk("R1 ptr", cmd_ptr, 32'd0);
        chk("R1 start", {30'b0, xfer_start, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            cmd = VECS[i][48:33];
            dv  = VECS[i][32:25];
            load_desc(cmd);
            dev_status = dv;
            go_and_settle();
            chk("R7 next ptr", cmd_ptr, {24'b0, VECS[i][23:16]});
            chk("R6 irq count", n_irq, {31'b0, VECS[i][24]});
            chk("R5 write-back", mem[19], {16'h8400 | {8'h00, dv}, VECS[i][15:0]});
            if (cmd[15:12] <= 4'd3) begin
                chk("R3 count", {16'b0, last_count}, 32'h10);
                chk("R3 key", {29'b0, last_key}, {29'b0, cmd[10:8]});
                chk("R3 addr", last_addr, 32'h1000);
            end else if (cmd[15:12] <= 4'd5) begin
                chk("R4 count", {16'b0, last_count}, 32'd4);
            end else begin
                chk("R5 no engine for no-op", n_starts, 32'd0);
            end
            stop_run();
        end

        // R2: fetch order and alignment of start address
        load_desc(16'h6000);
        start_addr = 32'h47;
        go_and_settle();
        chk("R2 read0", read_log[0], 32'h40);
        chk("R2 read1", read_log[1], 32'h44);
        chk("R2 read2", read_log[2], 32'h48);

        // R9: stop leaves pointer and descriptor untouched; wake refetches it
        chk("R9 ptr at stop", cmd_ptr, 32'h50);
        chk("R9 no write-back", mem[23], SENT);
        saved = read_n;
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        repeat (2) @(negedge clk);
        while (chan_active) @(negedge clk);
        chk("R9 wake refetch", read_n - saved, 32'd3);
        chk("R9 ptr after wake", cmd_ptr, 32'h50);
        stop_run();
        start_addr = 32'h40;

        // R8: wait holds then releases; R11 run drop while waiting
        load_desc(16'h6001);
        dev_status = 8'h04;
        n_irq = 0;
        read_n = 0;
        run = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8 waiting active", {31'b0, chan_active}, 32'd1);
        chk("R8 waiting ptr", cmd_ptr, 32'h40);
        chk("R8 wb before wait", mem[19], 32'h8404_0000);
        dev_status = 8'h00;
        repeat (2) @(negedge clk);
        while (chan_active) @(negedge clk);
        chk("R8 released ptr", cmd_ptr, 32'h50);
        stop_run();

        load_desc(16'h6001);
        dev_status = 8'h04;
        run = 1'b1;
        repeat (20) @(negedge clk);
        run = 1'b0;
        repeat (2) @(negedge clk);
        saved = read_n;
        chk("R11 idle inactive", {31'b0, chan_active}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R11 no fetch in idle", read_n - saved, 32'd0);
        dev_status = 8'h00;

        // R10: fetch error
        load_desc(16'h0000);
        err_on = 1'b1;
        err_addr = 8'h44;
        go_and_settle();
        chk("R10 dead on fetch err", {31'b0, chan_dead}, 32'd1);
        saved = read_n;
        repeat (10) @(negedge clk);
        chk("R10 quiet when dead", read_n - saved, 32'd0);
        stop_run();
        err_on = 1'b0;
        chk("R11 dead cleared", {31'b0, chan_dead}, 32'd0);

        // R10: engine error, no write-back
        load_desc(16'h0000);
        inj_xerr = 1'b1;
        go_and_settle();
        chk("R10 dead on engine err", {31'b0, chan_dead}, 32'd1);
        chk("R10 no wb after engine err", mem[19], SENT);
        stop_run();
        inj_xerr = 1'b0;

        // R10: undefined opcode
        load_desc(16'h9000);
        go_and_settle();
        chk("R10 dead on bad opcode", {31'b0, chan_dead}, 32'd1);
        chk("R10 no start on bad opcode", n_starts, 32'd0);
        stop_run();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule